// File: doc/BRIEF.md
# Program Counter and Branch Sequencer

This block owns the program counter of a small core with 12-bit instruction words. Each cycle it gives the fetch address of the next instruction word. The execute unit tells it what the instruction now executing does to control flow. The choices are plain sequential flow, an absolute jump, a subroutine call, or a return that also carries a literal for the working register. The execute unit can also request a skip or write a computed value into the counter from the data path. Subroutine return addresses are kept in a small hardware return stack inside the block.

Any change of flow leaves a word in the fetch path that must not run: a jump, call, return, computed write or taken skip. The sequencer handles this with a two-state machine. `ST_RUN` is the normal state, in which control inputs are acted on. A redirect moves it (transition `T_REDIRECT`) to `ST_BUBBLE`. For exactly one cycle in that state it raises `flush`, so that the execute unit runs the word in flight as a no-op. It ignores every control input in that cycle. It then returns to `ST_RUN` (transition `T_RESUME`). Without a redirect, `ST_RUN` stays where it is (transition `T_STAY`). Reset forces `ST_RUN` (transition `T_RESET`).

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `fetch_addr` is all ones (0x1FF), `flush` is 0 and `w_load_valid` is 0.
- R2: In `ST_RUN` with `ctl` = 2'b00 (sequential), no skip and no computed write, `fetch_addr` advances by one on the next edge, wrapping from 0x1FF to 0x000, and `flush` stays 0.
- R3: In `ST_RUN`, `ctl` = 2'b01 (jump) loads all 9 bits of `lit` into `fetch_addr` on the next edge and raises `flush` for that next cycle.
- R4: In `ST_RUN`, `ctl` = 2'b10 (call) pushes the current `fetch_addr` (the word after the call) onto the return stack. It loads `{1'b0, lit[7:0]}`, so bit 8 of the new address is always 0, and it raises `flush` in the next cycle.
- R5: In `ST_RUN`, `ctl` = 2'b11 (return) makes `w_load_valid` 1 in that same cycle, with `w_load_data` = `lit[7:0]`. On the next edge it loads `fetch_addr` from the most recent return-stack entry and raises `flush`.
- R6: The return stack holds two entries. A push when both are in use discards the oldest entry. A pop leaves the oldest entry in place, so further pops return that same address again.
- R7: In `ST_RUN` with `ctl` = 2'b00, `skip_req` = 1 advances `fetch_addr` by one and raises `flush` in the next cycle, so the skipped word costs one extra cycle.
- R8: In `ST_RUN`, `pc_wr` = 1 loads `{1'b0, pc_wdata}` and raises `flush` in the next cycle. It takes priority over `ctl` and `skip_req`: no push, no pop, and `w_load_valid` stays 0.
- R9: `flush` is never high for two cycles in a row. While it is high, `ctl`, `lit`, `skip_req` and `pc_wr` have no effect: `fetch_addr` advances by one, `w_load_valid` is 0, and the return stack is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl | input | 2 | Flow kind of executing word: 00 sequential, 01 jump, 10 call, 11 return |
| lit | input | 9 | Literal field of the executing word |
| skip_req | input | 1 | Execute unit requests that the next word be skipped |
| pc_wr | input | 1 | Computed write of the counter from the data path |
| pc_wdata | input | 8 | Value for the computed write |
| fetch_addr | output | 9 | Address of the instruction word to fetch |
| flush | output | 1 | Word now in execute must run as a no-op |
| w_load_valid | output | 1 | A return is executing; load `w_load_data` into W |
| w_load_data | output | 8 | Literal returned with the return |

## Verification
The assertions assume that `ctl`, `lit`, `skip_req`, `pc_wr` and `pc_wdata` are stable and known around each rising edge. They also assume that the execute unit keeps a skip request on sequential words only. The stimulus changes inputs only on falling edges and raises `skip_req` with `ctl` = 00, except during a flush cycle, where deliberately conflicting inputs test that they are ignored. The vectors push three calls to overflow the stack and pop past its depth. They also combine a computed write with a jump and a skip in the same cycle, and they wrap the counter through 0x1FF.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        CTL_SEQ   = 2'b00,
        CTL_GOTO  = 2'b01,
        CTL_CALL  = 2'b10,
        CTL_RETLW = 2'b11
    } ctl_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BUBBLE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int PC_W        = 9,
    parameter int STACK_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_val,
    output logic [PC_W-1:0] top
);

    logic [PC_W-1:0] ent [STACK_DEPTH];

    // Entry 0 is the most recent; the deepest entry is sticky on pop.
    for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push) begin
                    ent[i] <= push_val;
                end else if (pop && STACK_DEPTH > 1) begin
                    ent[i] <= ent[(STACK_DEPTH > 1) ? 1 : 0];
                end
            end
        end else if (i == STACK_DEPTH - 1) begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push) begin
                    ent[i] <= ent[i-1];
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push) begin
                    ent[i] <= ent[i-1];
                end else if (pop) begin
                    ent[i] <= ent[i+1];
                end
            end
        end
    end

    assign top = ent[0];

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int PC_W   = 9,
    parameter int DATA_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  ctl_e              ctl,
    input  logic [PC_W-1:0]   lit,
    input  logic              skip_req,
    input  logic              pc_wr,
    input  logic [DATA_W-1:0] pc_wdata,
    input  logic              in_bubble,
    input  logic [PC_W-1:0]   stack_top,
    output logic [PC_W-1:0]   pc_next,
    output logic              push,
    output logic              pop,
    output logic              redirect,
    output logic              ret_valid
);

    localparam int PAD_W = PC_W - DATA_W;

    logic [PC_W-1:0] pc_inc;
    assign pc_inc = pc + 1'b1;

    always_comb begin
        pc_next   = pc_inc;
        push      = 1'b0;
        pop       = 1'b0;
        redirect  = 1'b0;
        ret_valid = 1'b0;
        if (!in_bubble) begin
            if (pc_wr) begin
                pc_next  = {{PAD_W{1'b0}}, pc_wdata};
                redirect = 1'b1;
            end else begin
                unique case (ctl)
                    CTL_SEQ: begin
                        redirect = skip_req;
                    end
                    CTL_GOTO: begin
                        pc_next  = lit;
                        redirect = 1'b1;
                    end
                    CTL_CALL: begin
                        pc_next  = {{PAD_W{1'b0}}, lit[DATA_W-1:0]};
                        push     = 1'b1;
                        redirect = 1'b1;
                    end
                    CTL_RETLW: begin
                        pc_next   = stack_top;
                        pop       = 1'b1;
                        ret_valid = 1'b1;
                        redirect  = 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pcseq_fsm.sv
module pcseq_fsm
    import pcseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic redirect,
    output logic in_bubble
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    state_d = redirect ? ST_BUBBLE : ST_RUN;  // T_REDIRECT / T_STAY
            ST_BUBBLE: state_d = ST_RUN;                         // T_RESUME
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;                           // T_RESET
        else        state_q <= state_d;
    end

    always_comb begin
        in_bubble = 1'b0;
        unique case (state_q)
            ST_RUN:    in_bubble = 1'b0;
            ST_BUBBLE: in_bubble = 1'b1;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W        = 9,
    parameter int DATA_W      = 8,
    parameter int STACK_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl,
    input  logic [PC_W-1:0]   lit,
    input  logic              skip_req,
    input  logic              pc_wr,
    input  logic [DATA_W-1:0] pc_wdata,
    output logic [PC_W-1:0]   fetch_addr,
    output logic              flush,
    output logic              w_load_valid,
    output logic [DATA_W-1:0] w_load_data
);

    localparam logic [PC_W-1:0] RESET_PC = '1;

    logic [PC_W-1:0] pc_q, pc_next, stack_top;
    logic            push, pop, redirect, in_bubble, ret_valid;
    ctl_e            ctl_kind;

    assign ctl_kind = ctl_e'(ctl);

    pcseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .redirect  (redirect),
        .in_bubble (in_bubble)
    );

    pcseq_next #(.PC_W(PC_W), .DATA_W(DATA_W)) u_next (
        .pc        (pc_q),
        .ctl       (ctl_kind),
        .lit       (lit),
        .skip_req  (skip_req),
        .pc_wr     (pc_wr),
        .pc_wdata  (pc_wdata),
        .in_bubble (in_bubble),
        .stack_top (stack_top),
        .pc_next   (pc_next),
        .push      (push),
        .pop       (pop),
        .redirect  (redirect),
        .ret_valid (ret_valid)
    );

    pcseq_stack #(.PC_W(PC_W), .STACK_DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (pc_q),
        .top      (stack_top)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_next;
    end

    always_comb begin
        fetch_addr   = pc_q;
        flush        = in_bubble;
        w_load_valid = ret_valid;
        w_load_data  = lit[DATA_W-1:0];
    end

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int PC_W   = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ctl,
    input logic [PC_W-1:0]   lit,
    input logic              skip_req,
    input logic              pc_wr,
    input logic [DATA_W-1:0] pc_wdata,
    input logic [PC_W-1:0]   fetch_addr,
    input logic              flush,
    input logic              w_load_valid,
    input logic [DATA_W-1:0] w_load_data
);

    logic run_seq;
    assign run_seq = !flush && !pc_wr && ctl == 2'b00;

    a_r1_reset_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_addr == '1 && !flush && !w_load_valid));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_seq && !skip_req) |=> (!flush && fetch_addr == $past(fetch_addr) + 1'b1));

    a_r3_goto_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !pc_wr && ctl == 2'b01) |=> (flush && fetch_addr == $past(lit)));

    a_r4_call_page0: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !pc_wr && ctl == 2'b10) |=> (flush && !fetch_addr[PC_W-1]));

    a_r5_ret_literal: assert property (@(posedge clk) disable iff (!rst_n)
        w_load_valid |-> (!flush && !pc_wr && ctl == 2'b11 && w_load_data == lit[DATA_W-1:0]));

    a_r7_skip_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (run_seq && skip_req) |=> (flush && fetch_addr == $past(fetch_addr) + 1'b1));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && pc_wr) |=> (flush && fetch_addr == {1'b0, $past(pc_wdata)}));

    a_r9_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r9_bubble_step: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fetch_addr == $past(fetch_addr) + 1'b1);

    a_r9_no_ret_in_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !w_load_valid);

endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .lit          (lit),
    .skip_req     (skip_req),
    .pc_wr        (pc_wr),
    .pc_wdata     (pc_wdata),
    .fetch_addr   (fetch_addr),
    .flush        (flush),
    .w_load_valid (w_load_valid),
    .w_load_data  (w_load_data)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ctl = 2'b00;
    logic [8:0] lit = '0;
    logic       skip_req = 1'b0;
    logic       pc_wr = 1'b0;
    logic [7:0] pc_wdata = '0;
    logic [8:0] fetch_addr;
    logic       flush, w_load_valid;
    logic [7:0] w_load_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    pc_sequencer dut (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .lit(lit), .skip_req(skip_req),
        .pc_wr(pc_wr), .pc_wdata(pc_wdata), .fetch_addr(fetch_addr),
        .flush(flush), .w_load_valid(w_load_valid), .w_load_data(w_load_data)
    );

    // {pc_wr, pc_wdata, ctl, lit, skip_req, exp_fetch, exp_flush, exp_wv, exp_wd}
    localparam int NV = 24;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0, 8'h00}, // R2
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h001, 1'b0, 1'b0, 8'h00}, // R2
        {1'b0, 8'h00, 2'd1, 9'h150, 1'b0, 9'h150, 1'b1, 1'b0, 8'h00}, // R3
        {1'b0, 8'h00, 2'd2, 9'h023, 1'b0, 9'h151, 1'b0, 1'b0, 8'h00}, // R9 call ignored
        {1'b0, 8'h00, 2'd2, 9'h1A5, 1'b0, 9'h0A5, 1'b1, 1'b0, 8'h00}, // R4 bit 8 cleared
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h0A6, 1'b0, 1'b0, 8'h00},
        {1'b0, 8'h00, 2'd2, 9'h040, 1'b0, 9'h040, 1'b1, 1'b0, 8'h00}, // R4
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h041, 1'b0, 1'b0, 8'h00},
        {1'b0, 8'h00, 2'd2, 9'h060, 1'b0, 9'h060, 1'b1, 1'b0, 8'h00}, // R6 third push drops 151
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h061, 1'b0, 1'b0, 8'h00},
        {1'b0, 8'h00, 2'd3, 9'h03C, 1'b0, 9'h041, 1'b1, 1'b1, 8'h3C}, // R5
        {1'b0, 8'h00, 2'd3, 9'h099, 1'b0, 9'h042, 1'b0, 1'b0, 8'h00}, // R9 return ignored
        {1'b0, 8'h00, 2'd3, 9'h077, 1'b0, 9'h0A6, 1'b1, 1'b1, 8'h77}, // R6 second pop
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h0A7, 1'b0, 1'b0, 8'h00},
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b1, 9'h0A8, 1'b1, 1'b0, 8'h00}, // R7
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b1, 9'h0A9, 1'b0, 1'b0, 8'h00}, // R9 skip ignored
        {1'b1, 8'hF0, 2'd0, 9'h000, 1'b0, 9'h0F0, 1'b1, 1'b0, 8'h00}, // R8
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h0F1, 1'b0, 1'b0, 8'h00},
        {1'b1, 8'h10, 2'd1, 9'h1FF, 1'b1, 9'h010, 1'b1, 1'b0, 8'h00}, // R8 priority
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h011, 1'b0, 1'b0, 8'h00},
        {1'b0, 8'h00, 2'd1, 9'h1FF, 1'b0, 9'h1FF, 1'b1, 1'b0, 8'h00}, // R3 full 9 bits
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0, 8'h00}, // R2 wrap
        {1'b0, 8'h00, 2'd3, 9'h005, 1'b0, 9'h0A6, 1'b1, 1'b1, 8'h05}, // R6 oldest sticks
        {1'b0, 8'h00, 2'd0, 9'h000, 1'b0, 9'h0A7, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [39:0] v, input bit prev_flush);
        if (prev_flush)            return "R9";
        if (v[39])                 return "R8";
        if (v[30:29] == 2'd1)      return "R3";
        if (v[30:29] == 2'd2)      return "R4";
        if (v[30:29] == 2'd3)      return "R5";
        if (v[19])                 return "R7";
        return "R2";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        bit prev_flush;
        repeat (3) @(negedge clk);
        check("R1", "fetch in reset", 16'(fetch_addr), 16'h1FF);
        rst_n = 1'b1;
        #1;
        check("R1", "fetch after release", 16'(fetch_addr), 16'h1FF);
        check("R1", "flush after release", 16'(flush), 16'h0);
        check("R1", "wload after release", 16'(w_load_valid), 16'h0);

        prev_flush = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v, prev_flush);
            {pc_wr, pc_wdata, ctl, lit, skip_req} = v[39:19];
            #1;
            check(t, "w_load_valid", 16'(w_load_valid), 16'(v[8]));
            if (v[8]) check(t, "w_load_data", 16'(w_load_data), 16'(v[7:0]));
            @(negedge clk);
            check(t, "fetch_addr", 16'(fetch_addr), 16'(v[18:10]));
            check(t, "flush", 16'(flush), 16'(v[9]));
            prev_flush = v[9];
        end

        // R1: reset in the middle of a redirect
        {pc_wr, pc_wdata, ctl, lit, skip_req} = {1'b0, 8'h00, 2'd1, 9'h0C3, 1'b0};
        @(negedge clk);
        check("R3", "fetch before reset", 16'(fetch_addr), 16'h0C3);
        rst_n = 1'b0;
        #1;
        check("R1", "fetch mid reset", 16'(fetch_addr), 16'h1FF);
        check("R1", "flush mid reset", 16'(flush), 16'h0);
        {pc_wr, pc_wdata, ctl, lit, skip_req} = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "wrap after reset", 16'(fetch_addr), 16'h000);
        check("R2", "no flush after step", 16'(flush), 16'h0);
        finish_run();
    end

endmodule